// File: doc/BRIEF.md
# Power-Management Two-Wire Bus Host Controller

This block is the register-side half of a host for a reduced two-wire bus that links a system chip to its power-management ICs. Software programs a small set of 32-bit registers (command opcode, run-time and device addresses, data address, data length, write data) and then sets a start bit. The controller freezes that programming into a job and raises a request to an external line engine, which drives the wire. The line engine answers with a one-cycle done pulse, optionally flagged as an error with a 4-bit reason code.

On completion the controller sets a write-one-to-clear status bit and, for reads, stores the returned bytes in data word 0 with byte 0 in bits 7:0. The stored bytes are trimmed to the 1, 2 or 4 bytes that the opcode names. A second trigger, in the power-management init register, launches a one-shot register write that carries its own target register and data byte. A start attempt while a job is running only records a load-busy flag. A self-clearing soft reset returns every register to zero and abandons any running job. An interrupt line combines the status bits, their enables and a global enable.

Top module: `pwrbus_host`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `eng_req` is low.
- R2: Writing the control register at offset 0x00 with bit 7 set while idle raises `eng_req` after that clock edge. `eng_cmd`, `eng_rta`, `eng_dev`, `eng_addr`, `eng_alen` and `eng_read` then present the command (0x2C), device-address (0x30: run-time address bits 23:16, device address bits 15:0), data address 0 (0x10) and data-length (0x18) values, with `eng_is_init` low. Control bit 7 reads 1 while the job runs.
- R3: A done pulse without error while `eng_req` is high sets status (offset 0x0C) bit 0. On the next edge it clears `eng_req` and control bit 7.
- R4: A done pulse with `eng_err` high sets status bit 1 and places `eng_err_code` in status bits 11:8, leaves bit 0 clear and leaves data word 0 unchanged.
- R5: When data-length bit 4 (read) is set and the job ends without error, data word 0 (offset 0x1C) takes `eng_rdata` trimmed by opcode. For 0x8B bits 7:0 are kept; for 0x9C bits 15:0 are kept; for any other opcode, such as 0xA6, all 32 bits are kept. The dropped bits read zero.
- R6: `eng_wdata` is data word 0 captured at start and trimmed by opcode (0x4E keeps 8 bits, 0x59 keeps 16, others 32). Writes to data word 0 during the job do not change it.
- R7: A start (control bit 7) or init trigger (offset 0x28 bit 31) while a job runs sets status bit 2 and leaves `eng_req` and all job outputs unchanged.
- R8: Writing the status register clears exactly the bits written as one. Clearing bit 1 also zeroes bits 11:8. A completion in the same cycle wins over the clear.
- R9: `irq` is high exactly when control bit 1 is set and some status bit 2:0 is set together with the same bit of the interrupt enable register (offset 0x08).
- R10: Writing control bit 0 makes it read 1 for one cycle. At the next edge every register, status and running job is cleared and `eng_req` drops.
- R11: Writing offset 0x28 with bit 31 set while idle starts a job with `eng_is_init` high, `eng_init_reg` = bits 15:8 and `eng_init_val` = bits 23:16. Bit 31 reads 1 until done, and done sets status bit 0.
- R12: Readback keeps only the implemented fields. Data length reads bits 4 and 2:0, the command register bits 7:0, the device-address register bits 23:0 and interrupt enable bits 2:0. The clock-control register (0x04), data address 1 (0x14) and data word 1 (0x20) keep all 32 bits, and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | ADDR_W | Register byte offset |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data for `host_addr` (combinational) |
| irq | output | 1 | Interrupt request |
| eng_req | output | 1 | Job request to the line engine, held until done |
| eng_is_init | output | 1 | Job is a one-shot init register write |
| eng_cmd | output | 8 | Command opcode of the job |
| eng_rta | output | 8 | Run-time address of the job |
| eng_dev | output | 16 | Device address of the job |
| eng_addr | output | 32 | Data address of the job |
| eng_alen | output | 3 | Address byte count minus one |
| eng_read | output | 1 | Job is a read |
| eng_wdata | output | 32 | Trimmed write data |
| eng_init_reg | output | 8 | Target register of an init job |
| eng_init_val | output | 8 | Data byte of an init job |
| eng_done | input | 1 | One-cycle completion pulse |
| eng_err | input | 1 | Completion is an error (valid with done) |
| eng_err_code | input | 4 | Error reason (valid with done) |
| eng_rdata | input | 32 | Read data (valid with done) |

## Verification
The main path is exercised with 8-, 16- and 32-bit read opcodes against one fixed return word, so a wrong trim width shows up as extra or missing bytes in data word 0. A 16-bit write is also exercised, with data word 0 rewritten mid-job, which separates a captured write word from a live one. An erroring read, an init job, a start collision and a soft reset in the middle of a job tell apart the error path, the second trigger, the load-busy path and the abort path. A cycle-level model of busy, status and interrupt runs beside the block on every clock.

// File: rtl/pwrbus_pkg.sv
package pwrbus_pkg;

    localparam int DATA_W = 32;
    localparam int ALEN_W = 3;
    localparam int STS_W  = 3;
    localparam int CODE_W = 4;

    // Register byte offsets
    localparam int unsigned OFF_CTRL  = 32'h00;
    localparam int unsigned OFF_CLK   = 32'h04;
    localparam int unsigned OFF_IEN   = 32'h08;
    localparam int unsigned OFF_STS   = 32'h0C;
    localparam int unsigned OFF_ADR0  = 32'h10;
    localparam int unsigned OFF_ADR1  = 32'h14;
    localparam int unsigned OFF_LEN   = 32'h18;
    localparam int unsigned OFF_DAT0  = 32'h1C;
    localparam int unsigned OFF_DAT1  = 32'h20;
    localparam int unsigned OFF_INIT  = 32'h28;
    localparam int unsigned OFF_CMD   = 32'h2C;
    localparam int unsigned OFF_DEVA  = 32'h30;

    // Control bits
    localparam int CTRL_GO   = 7;
    localparam int CTRL_GIE  = 1;
    localparam int CTRL_SRST = 0;

    // Status bits
    localparam int STS_DONE = 0;
    localparam int STS_FAIL = 1;
    localparam int STS_LBSY = 2;
    localparam int STS_CODE_LSB = 8;

    localparam int LEN_RD = 4;
    localparam int INIT_GO = 31;

    // Opcodes
    localparam logic [7:0] OPC_SETRTA = 8'hE8;
    localparam logic [7:0] OPC_RD8    = 8'h8B;
    localparam logic [7:0] OPC_RD16   = 8'h9C;
    localparam logic [7:0] OPC_RD32   = 8'hA6;
    localparam logic [7:0] OPC_WR8    = 8'h4E;
    localparam logic [7:0] OPC_WR16   = 8'h59;
    localparam logic [7:0] OPC_WR32   = 8'h63;

    typedef enum logic {JOB_XFER = 1'b0, JOB_INIT = 1'b1} job_kind_e;

    typedef struct packed {
        job_kind_e          kind;
        logic [7:0]         cmd;
        logic [7:0]         rta;
        logic [15:0]        dev;
        logic [DATA_W-1:0]  addr;
        logic [ALEN_W-1:0]  alen;
        logic               rd;
        logic [DATA_W-1:0]  wdata;
        logic [7:0]         ireg;
        logic [7:0]         ival;
    } job_t;

    // Byte-lane mask selected by the width encoded in an opcode
    function automatic logic [DATA_W-1:0] lane_mask(input logic [7:0] opc);
        logic [DATA_W-1:0] m;
        case (opc)
            OPC_RD8,  OPC_WR8:  m = DATA_W'(32'h0000_00FF);
            OPC_RD16, OPC_WR16: m = DATA_W'(32'h0000_FFFF);
            default:            m = '1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pwrbus_regs.sv
module pwrbus_regs
    import pwrbus_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_wr,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [DATA_W-1:0]   host_wdata,
    output logic [DATA_W-1:0]   host_rdata,
    input  logic                busy_xfer,
    input  logic                busy_init,
    input  logic [STS_W-1:0]    sts,
    input  logic [CODE_W-1:0]   sts_code,
    input  logic                cap_en,
    input  logic [DATA_W-1:0]   cap_data,
    output logic                clr,
    output logic                go,
    output logic [STS_W-1:0]    sts_clr,
    output logic                gie,
    output logic [STS_W-1:0]    ien,
    output job_t                cfg
);

    logic                srst_q, gie_q, rd_q;
    logic [DATA_W-1:0]   clk_q, adr0_q, adr1_q, dat0_q, dat1_q;
    logic [STS_W-1:0]    ien_q;
    logic [ALEN_W-1:0]   alen_q;
    logic [7:0]          cmd_q, rta_q, ireg_q, ival_q;
    logic [15:0]         dev_q;
    logic                busy;

    logic w_ctrl, w_clk, w_ien, w_sts, w_adr0, w_adr1, w_len;
    logic w_dat0, w_dat1, w_init, w_cmd, w_deva;

    always_comb begin
        w_ctrl = host_wr && (host_addr == ADDR_W'(OFF_CTRL));
        w_clk  = host_wr && (host_addr == ADDR_W'(OFF_CLK));
        w_ien  = host_wr && (host_addr == ADDR_W'(OFF_IEN));
        w_sts  = host_wr && (host_addr == ADDR_W'(OFF_STS));
        w_adr0 = host_wr && (host_addr == ADDR_W'(OFF_ADR0));
        w_adr1 = host_wr && (host_addr == ADDR_W'(OFF_ADR1));
        w_len  = host_wr && (host_addr == ADDR_W'(OFF_LEN));
        w_dat0 = host_wr && (host_addr == ADDR_W'(OFF_DAT0));
        w_dat1 = host_wr && (host_addr == ADDR_W'(OFF_DAT1));
        w_init = host_wr && (host_addr == ADDR_W'(OFF_INIT));
        w_cmd  = host_wr && (host_addr == ADDR_W'(OFF_CMD));
        w_deva = host_wr && (host_addr == ADDR_W'(OFF_DEVA));
    end

    assign busy    = busy_xfer | busy_init;
    assign clr     = rst | srst_q;
    assign go      = (w_ctrl & host_wdata[CTRL_GO]) | (w_init & host_wdata[INIT_GO]);
    assign sts_clr = w_sts ? host_wdata[STS_W-1:0] : '0;
    assign gie     = gie_q;
    assign ien     = ien_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            srst_q <= 1'b0;
            gie_q  <= 1'b0;
            rd_q   <= 1'b0;
            clk_q  <= '0;
            adr0_q <= '0;
            adr1_q <= '0;
            dat0_q <= '0;
            dat1_q <= '0;
            ien_q  <= '0;
            alen_q <= '0;
            cmd_q  <= '0;
            rta_q  <= '0;
            dev_q  <= '0;
            ireg_q <= '0;
            ival_q <= '0;
        end else begin
            if (w_ctrl) begin
                gie_q  <= host_wdata[CTRL_GIE];
                srst_q <= host_wdata[CTRL_SRST];
            end
            if (w_clk)  clk_q  <= host_wdata;
            if (w_ien)  ien_q  <= host_wdata[STS_W-1:0];
            if (w_adr0) adr0_q <= host_wdata;
            if (w_adr1) adr1_q <= host_wdata;
            if (w_len) begin
                rd_q   <= host_wdata[LEN_RD];
                alen_q <= host_wdata[ALEN_W-1:0];
            end
            if (cap_en)      dat0_q <= cap_data;
            else if (w_dat0) dat0_q <= host_wdata;
            if (w_dat1) dat1_q <= host_wdata;
            if (w_cmd)  cmd_q  <= host_wdata[7:0];
            if (w_deva) begin
                rta_q <= host_wdata[23:16];
                dev_q <= host_wdata[15:0];
            end
            if (w_init && !busy) begin
                ireg_q <= host_wdata[15:8];
                ival_q <= host_wdata[23:16];
            end
        end
    end

    // Job as it would be captured by a trigger in this cycle
    always_comb begin
        cfg.kind  = w_init ? JOB_INIT : JOB_XFER;
        cfg.cmd   = cmd_q;
        cfg.rta   = rta_q;
        cfg.dev   = dev_q;
        cfg.addr  = adr0_q;
        cfg.alen  = alen_q;
        cfg.rd    = rd_q;
        cfg.wdata = dat0_q;
        cfg.ireg  = w_init ? host_wdata[15:8]  : ireg_q;
        cfg.ival  = w_init ? host_wdata[23:16] : ival_q;
    end

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            ADDR_W'(OFF_CTRL): begin
                host_rdata[CTRL_GO]   = busy_xfer;
                host_rdata[CTRL_GIE]  = gie_q;
                host_rdata[CTRL_SRST] = srst_q;
            end
            ADDR_W'(OFF_CLK):  host_rdata = clk_q;
            ADDR_W'(OFF_IEN):  host_rdata[STS_W-1:0] = ien_q;
            ADDR_W'(OFF_STS): begin
                host_rdata[STS_W-1:0] = sts;
                host_rdata[STS_CODE_LSB +: CODE_W] = sts_code;
            end
            ADDR_W'(OFF_ADR0): host_rdata = adr0_q;
            ADDR_W'(OFF_ADR1): host_rdata = adr1_q;
            ADDR_W'(OFF_LEN): begin
                host_rdata[LEN_RD] = rd_q;
                host_rdata[ALEN_W-1:0] = alen_q;
            end
            ADDR_W'(OFF_DAT0): host_rdata = dat0_q;
            ADDR_W'(OFF_DAT1): host_rdata = dat1_q;
            ADDR_W'(OFF_INIT): begin
                host_rdata[INIT_GO] = busy_init;
                host_rdata[23:16]   = ival_q;
                host_rdata[15:8]    = ireg_q;
            end
            ADDR_W'(OFF_CMD):  host_rdata[7:0] = cmd_q;
            ADDR_W'(OFF_DEVA): host_rdata[23:0] = {rta_q, dev_q};
            default:           host_rdata = '0;
        endcase
    end

    AST_SRST_SELF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        srst_q |=> !srst_q); // R10

    AST_SRST_WIPES_CMD: assert property (@(posedge clk) disable iff (rst)
        srst_q |=> (cmd_q == '0) && (dat0_q == '0) && !gie_q); // R10

endmodule

// File: rtl/pwrbus_seq.sv
module pwrbus_seq
    import pwrbus_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                go,
    input  logic [STS_W-1:0]    sts_clr,
    input  job_t                cfg,
    input  logic                eng_done,
    input  logic                eng_err,
    input  logic [CODE_W-1:0]   eng_err_code,
    input  logic [DATA_W-1:0]   eng_rdata,
    output logic                busy,
    output job_t                job,
    output logic [STS_W-1:0]    sts,
    output logic [CODE_W-1:0]   sts_code,
    output logic                cap_en,
    output logic [DATA_W-1:0]   cap_data
);

    logic               busy_q;
    job_t               job_q, job_in;
    logic [STS_W-1:0]   sts_q, sts_set;
    logic [CODE_W-1:0]  code_q;
    logic               fin;

    always_comb begin
        fin     = busy_q & eng_done;
        sts_set = '0;
        if (fin) begin
            if (eng_err) sts_set[STS_FAIL] = 1'b1;
            else         sts_set[STS_DONE] = 1'b1;
        end
        if (go && busy_q) sts_set[STS_LBSY] = 1'b1;

        job_in       = cfg;
        job_in.wdata = cfg.wdata & lane_mask(cfg.cmd);

        cap_en   = fin & ~eng_err & (job_q.kind == JOB_XFER) & job_q.rd;
        cap_data = eng_rdata & lane_mask(job_q.cmd);
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            busy_q <= 1'b0;
            job_q  <= '0;
            sts_q  <= '0;
            code_q <= '0;
        end else begin
            if (fin) begin
                busy_q <= 1'b0;
            end else if (go && !busy_q) begin
                busy_q <= 1'b1;
                job_q  <= job_in;
            end
            sts_q <= (sts_q & ~sts_clr) | sts_set;
            if (fin && eng_err)       code_q <= eng_err_code;
            else if (sts_clr[STS_FAIL]) code_q <= '0;
        end
    end

    assign busy     = busy_q;
    assign job      = job_q;
    assign sts      = sts_q;
    assign sts_code = code_q;

    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (busy_q && eng_done && !clr) |=> !busy_q); // R3

    AST_FAIL_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (busy_q && eng_done && eng_err && !clr) |=> sts_q[STS_FAIL] && (code_q == $past(eng_err_code))); // R4

    AST_JOB_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !clr) |=> $stable(job_q)); // R6

    AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !eng_done && go && !clr) |=> busy_q && sts_q[STS_LBSY]); // R7

    AST_W1C_DONE: assert property (@(posedge clk) disable iff (rst)
        (sts_clr[STS_DONE] && !fin && !clr) |=> !sts_q[STS_DONE]); // R8

endmodule

// File: rtl/pwrbus_irq.sv
module pwrbus_irq
    import pwrbus_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                gie,
    input  logic [STS_W-1:0]    ien,
    input  logic [STS_W-1:0]    sts,
    output logic                irq
);

    assign irq = gie & (|(sts & ien));

    AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst)
        irq |-> gie); // R9

    AST_IRQ_NEEDS_SRC: assert property (@(posedge clk) disable iff (rst)
        (sts == '0) |-> !irq); // R9

endmodule

// File: rtl/pwrbus_host.sv
module pwrbus_host
    import pwrbus_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_wr,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [31:0]         host_wdata,
    output logic [31:0]         host_rdata,
    output logic                irq,
    output logic                eng_req,
    output logic                eng_is_init,
    output logic [7:0]          eng_cmd,
    output logic [7:0]          eng_rta,
    output logic [15:0]         eng_dev,
    output logic [31:0]         eng_addr,
    output logic [2:0]          eng_alen,
    output logic                eng_read,
    output logic [31:0]         eng_wdata,
    output logic [7:0]          eng_init_reg,
    output logic [7:0]          eng_init_val,
    input  logic                eng_done,
    input  logic                eng_err,
    input  logic [3:0]          eng_err_code,
    input  logic [31:0]         eng_rdata
);

    logic               clr, go, busy, gie, cap_en;
    logic [STS_W-1:0]   sts_clr, ien, sts;
    logic [CODE_W-1:0]  sts_code;
    logic [DATA_W-1:0]  cap_data;
    job_t               cfg, job;
    logic               busy_xfer, busy_init;

    assign busy_xfer = busy & (job.kind == JOB_XFER);
    assign busy_init = busy & (job.kind == JOB_INIT);

    pwrbus_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .busy_xfer  (busy_xfer),
        .busy_init  (busy_init),
        .sts        (sts),
        .sts_code   (sts_code),
        .cap_en     (cap_en),
        .cap_data   (cap_data),
        .clr        (clr),
        .go         (go),
        .sts_clr    (sts_clr),
        .gie        (gie),
        .ien        (ien),
        .cfg        (cfg)
    );

    pwrbus_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .clr          (clr),
        .go           (go),
        .sts_clr      (sts_clr),
        .cfg          (cfg),
        .eng_done     (eng_done),
        .eng_err      (eng_err),
        .eng_err_code (eng_err_code),
        .eng_rdata    (eng_rdata),
        .busy         (busy),
        .job          (job),
        .sts          (sts),
        .sts_code     (sts_code),
        .cap_en       (cap_en),
        .cap_data     (cap_data)
    );

    pwrbus_irq u_irq (
        .clk  (clk),
        .rst  (rst),
        .gie  (gie),
        .ien  (ien),
        .sts  (sts),
        .irq  (irq)
    );

    assign eng_req      = busy;
    assign eng_is_init  = (job.kind == JOB_INIT);
    assign eng_cmd      = job.cmd;
    assign eng_rta      = job.rta;
    assign eng_dev      = job.dev;
    assign eng_addr     = job.addr;
    assign eng_alen     = job.alen;
    assign eng_read     = job.rd;
    assign eng_wdata    = job.wdata;
    assign eng_init_reg = job.ireg;
    assign eng_init_val = job.ival;

endmodule

// File: tb/tb_pwrbus_host.sv
`timescale 1ns/1ps
module tb_pwrbus_host;
    import pwrbus_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        irq, eng_req, eng_is_init, eng_read;
    logic [7:0]  eng_cmd, eng_rta, eng_init_reg, eng_init_val;
    logic [15:0] eng_dev;
    logic [31:0] eng_addr, eng_wdata;
    logic [2:0]  eng_alen;
    logic        eng_done = 1'b0;
    logic        eng_err = 1'b0;
    logic [3:0]  eng_err_code = '0;
    logic [31:0] eng_rdata = 32'hA1B2_C3D4;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // stub controls
    int  stub_lat = 3;
    bit  stub_err = 0;
    logic [3:0] stub_code = '0;
    int  stub_cnt = 0;

    // reference model state
    bit         m_busy = 0, m_gie = 0, m_srst = 0;
    logic [2:0] m_sts = '0, m_ien = '0;
    logic [3:0] m_code = '0;

    always #5 clk = ~clk;

    pwrbus_host #(.ADDR_W(8)) dut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
        .eng_req(eng_req), .eng_is_init(eng_is_init), .eng_cmd(eng_cmd),
        .eng_rta(eng_rta), .eng_dev(eng_dev), .eng_addr(eng_addr),
        .eng_alen(eng_alen), .eng_read(eng_read), .eng_wdata(eng_wdata),
        .eng_init_reg(eng_init_reg), .eng_init_val(eng_init_val),
        .eng_done(eng_done), .eng_err(eng_err), .eng_err_code(eng_err_code),
        .eng_rdata(eng_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural line engine stub
    always @(negedge clk) begin
        if (!eng_req) begin
            stub_cnt = 0;
            eng_done <= 1'b0;
        end else if (eng_done) begin
            eng_done <= 1'b0;
        end else begin
            stub_cnt++;
            if (stub_cnt >= stub_lat) begin
                eng_done     <= 1'b1;
                eng_err      <= stub_err;
                eng_err_code <= stub_code;
            end
        end
    end

    // cycle model of busy, status and interrupt
    always @(posedge clk) begin
        logic [2:0] st_set, st_clr;
        bit was_busy;
        if (rst || m_srst) begin
            m_busy = 0; m_gie = 0; m_srst = 0;
            m_sts = '0; m_ien = '0; m_code = '0;
        end else begin
            st_set = '0; st_clr = '0; was_busy = m_busy;
            if (was_busy && eng_done) begin
                m_busy = 0;
                if (eng_err) st_set[1] = 1'b1; else st_set[0] = 1'b1;
            end
            if (host_wr) begin
                if (host_addr == 8'(OFF_CTRL)) begin
                    m_gie = host_wdata[1];
                    if (host_wdata[0]) m_srst = 1;
                    if (host_wdata[7]) begin
                        if (was_busy) st_set[2] = 1'b1; else m_busy = 1;
                    end
                end else if (host_addr == 8'(OFF_INIT) && host_wdata[31]) begin
                    if (was_busy) st_set[2] = 1'b1; else m_busy = 1;
                end else if (host_addr == 8'(OFF_IEN)) begin
                    m_ien = host_wdata[2:0];
                end else if (host_addr == 8'(OFF_STS)) begin
                    st_clr = host_wdata[2:0];
                end
            end
            m_sts = (m_sts & ~st_clr) | st_set;
            if (st_set[1]) m_code = eng_err_code;
            else if (st_clr[1]) m_code = '0;
        end
    end

    // compare every clock: request line (R2/R3) and interrupt (R9)
    always @(negedge clk) begin
        if (!rst) begin
            chk("R2 eng_req vs model", {31'b0, eng_req}, {31'b0, m_busy});
            chk("R9 irq vs model", {31'b0, irq}, {31'b0, m_gie && |(m_sts & m_ien)});
        end
    end

    task automatic wr(input int unsigned a, input logic [31:0] d);
        host_wr = 1'b1; host_addr = 8'(a); host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input int unsigned a, output logic [31:0] d);
        host_addr = 8'(a);
        #1;
        d = host_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 1000 && eng_req; i++) @(negedge clk);
    endtask

    task automatic chk_sts(input string req);
        logic [31:0] v;
        rd(OFF_STS, v);
        chk(req, v, {20'b0, m_code, 5'b0, m_sts});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick();

        // R1 reset state
        rd(OFF_CTRL, v); chk("R1 ctrl", v, 0);
        rd(OFF_STS, v);  chk("R1 status", v, 0);
        rd(OFF_CMD, v);  chk("R1 cmd", v, 0);
        rd(OFF_DAT0, v); chk("R1 data0", v, 0);
        rd(OFF_INIT, v); chk("R1 init", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 eng_req", {31'b0, eng_req}, 0);

        // R12 readback masks
        wr(OFF_LEN, 32'hFFFF_FFFF);  rd(OFF_LEN, v);  chk("R12 len", v, 32'h17);
        wr(OFF_CMD, 32'hFFFF_FFFF);  rd(OFF_CMD, v);  chk("R12 cmd", v, 32'hFF);
        wr(OFF_DEVA, 32'hFFFF_FFFF); rd(OFF_DEVA, v); chk("R12 dev addr", v, 32'h00FF_FFFF);
        wr(OFF_IEN, 32'hFFFF_FFFF);  rd(OFF_IEN, v);  chk("R12 ien", v, 32'h7);
        wr(OFF_CLK, 32'hDEAD_BEEF);  rd(OFF_CLK, v);  chk("R12 clk ctrl", v, 32'hDEAD_BEEF);
        wr(OFF_DAT1, 32'h1234_5678); rd(OFF_DAT1, v); chk("R12 data1", v, 32'h1234_5678);
        rd(32'h24, v); chk("R12 unmapped", v, 0);
        wr(OFF_IEN, 0);

        // R2 R3 R5: 8-bit read
        wr(OFF_CMD, OPC_RD8);
        wr(OFF_DEVA, 32'h002D_03A3);
        wr(OFF_ADR0, 32'h0000_0042);
        wr(OFF_LEN, 32'h10);
        wr(OFF_CTRL, 32'h80);
        chk("R2 req", {31'b0, eng_req}, 1);
        chk("R2 cmd", {24'b0, eng_cmd}, 32'h8B);
        chk("R2 rta", {24'b0, eng_rta}, 32'h2D);
        chk("R2 dev", {16'b0, eng_dev}, 32'h03A3);
        chk("R2 addr", eng_addr, 32'h42);
        chk("R2 alen/read/init", {27'b0, eng_alen, eng_read, eng_is_init}, {27'b0, 3'd0, 1'b1, 1'b0});
        rd(OFF_CTRL, v); chk("R2 start bit reads 1", v, 32'h80);
        wait_idle();
        rd(OFF_CTRL, v); chk("R3 start bit cleared", v, 0);
        chk_sts("R3 done status");
        rd(OFF_DAT0, v); chk("R5 read8 data", v, 32'hD4);

        // R8 write-one-to-clear
        wr(OFF_STS, 32'h1); chk_sts("R8 cleared done");
        rd(OFF_STS, v); chk("R8 status zero", v, 0);

        // R5 16- and 32-bit reads
        wr(OFF_CMD, OPC_RD16); wr(OFF_CTRL, 32'h80); wait_idle();
        rd(OFF_DAT0, v); chk("R5 read16 data", v, 32'hC3D4);
        wr(OFF_CMD, OPC_RD32); wr(OFF_CTRL, 32'h80); wait_idle();
        rd(OFF_DAT0, v); chk("R5 read32 data", v, 32'hA1B2_C3D4);
        wr(OFF_STS, 32'h7); chk_sts("R8 clear all");

        // R6 R7: 16-bit write, data word rewritten mid-job, start collision
        stub_lat = 20;
        wr(OFF_CMD, OPC_WR16);
        wr(OFF_LEN, 32'h0);
        wr(OFF_DAT0, 32'h1122_3344);
        wr(OFF_CTRL, 32'h80);
        chk("R6 wdata trimmed", eng_wdata, 32'h3344);
        wr(OFF_DAT0, 32'hFFFF_FFFF);
        chk("R6 wdata frozen", eng_wdata, 32'h3344);
        wr(OFF_CMD, OPC_WR8);
        wr(OFF_CTRL, 32'h80);
        chk("R7 cmd unchanged", {24'b0, eng_cmd}, 32'h59);
        chk("R7 still busy", {31'b0, eng_req}, 1);
        wr(OFF_INIT, 32'h8011_2200);
        chk("R7 init ignored", {31'b0, eng_is_init}, 0);
        chk_sts("R7 load busy set");
        wait_idle();
        chk_sts("R7 done plus load busy");
        rd(OFF_STS, v); chk("R7 status value", v, 32'h5);
        wr(OFF_STS, 32'h7);
        stub_lat = 3;

        // R4 failing read keeps data0
        wr(OFF_DAT0, 32'h55);
        wr(OFF_CMD, OPC_RD8);
        wr(OFF_LEN, 32'h10);
        stub_err = 1; stub_code = 4'h5;
        wr(OFF_CTRL, 32'h80); wait_idle();
        stub_err = 0; stub_code = 4'h0;
        rd(OFF_STS, v); chk("R4 error status", v, 32'h502);
        chk_sts("R4 model status");
        rd(OFF_DAT0, v); chk("R4 data0 kept", v, 32'h55);
        wr(OFF_STS, 32'h2); rd(OFF_STS, v); chk("R8 code cleared with bit1", v, 0);

        // R11 init job
        stub_lat = 6;
        wr(OFF_INIT, 32'h807C_3E00);
        chk("R11 init kind", {31'b0, eng_is_init}, 1);
        chk("R11 init reg", {24'b0, eng_init_reg}, 32'h3E);
        chk("R11 init val", {24'b0, eng_init_val}, 32'h7C);
        rd(OFF_INIT, v); chk("R11 bit31 busy", v, 32'h807C_3E00);
        rd(OFF_CTRL, v); chk("R11 ctrl go low", v, 0);
        wait_idle();
        rd(OFF_INIT, v); chk("R11 bit31 cleared", v, 32'h007C_3E00);
        chk_sts("R11 done status");
        wr(OFF_STS, 32'h7);
        stub_lat = 3;

        // R9 interrupt gating
        wr(OFF_IEN, 32'h1);
        wr(OFF_CMD, OPC_WR8);
        wr(OFF_CTRL, 32'h80); wait_idle();
        chk("R9 irq low without gie", {31'b0, irq}, 0);
        wr(OFF_CTRL, 32'h2);
        chk("R9 irq high", {31'b0, irq}, 1);
        wr(OFF_IEN, 32'h2);
        chk("R9 irq low unmatched enable", {31'b0, irq}, 0);
        wr(OFF_IEN, 32'h1);
        wr(OFF_STS, 32'h1);
        chk("R9 irq low after clear", {31'b0, irq}, 0);

        // R10 soft reset during a job
        stub_lat = 30;
        wr(OFF_CTRL, 32'h80);
        chk("R10 job running", {31'b0, eng_req}, 1);
        wr(OFF_CTRL, 32'h1);
        rd(OFF_CTRL, v); chk("R10 reset bit reads 1", v, 32'h81);
        tick();
        rd(OFF_CTRL, v); chk("R10 ctrl cleared", v, 0);
        chk("R10 req dropped", {31'b0, eng_req}, 0);
        rd(OFF_CMD, v);  chk("R10 cmd cleared", v, 0);
        rd(OFF_IEN, v);  chk("R10 ien cleared", v, 0);
        rd(OFF_CLK, v);  chk("R10 clk ctrl cleared", v, 0);
        chk_sts("R10 status cleared");
        repeat (40) tick();
        chk("R10 stays idle", {31'b0, eng_req}, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule